// File: doc/BRIEF.md
# Nested Trap Level State Stack

This block holds the nested trap context of a 64-bit processor core. It keeps the current trap level and the processor-state and window-pointer registers. It also holds an eight-slot stack of saved trap frames. Each frame stores the trap PC, the trap next PC and a packed saved-state word. When a trap is accepted, the level rises and a frame is written in the same cycle. The frame is stored in the slot that the new level selects. A return (done or retry) restores the processor state and the window pointer from the frame at the current level. The return then lowers the level and presents the PC to resume at.

The deepest allowed nesting comes from a runtime input, clamped into the range 1 to 8. The stack always has eight physical slots and is indexed by the low three bits of the level. When a trap lands on the last level below the limit, the block sets the reduced-function (RED) bit of the processor state. A trap that arrives with no level left moves the controller from state `ST_RUN` into state `ST_ERR`. The only transition out of `ST_ERR` is reset. In `ST_ERR` every request is ignored and the error output stays high. The core may write the processor state and window pointer directly when no trap or return is being requested.

Top module: `trap_level_stack`

## Requirements
- R1: On reset the level equals the effective maximum level. The processor state is 0x004 (privileged bit 2 set), the window pointer is 0, the resume PC is 0 and every stack slot holds zero.
- R2: The effective maximum is 1 when `max_tl_i` is 0, is 8 when `max_tl_i` is above 8, and is otherwise `max_tl_i`. `version_o[15:8]` shows the effective maximum and `version_o[7:0]` shows the window count minus one (7).
- R3: A trap taken in `ST_RUN` while the level is below the effective maximum minus one raises the level by one and leaves the processor state unchanged.
- R4: A trap taken at level equal to the effective maximum minus one sets processor-state bit 5 (RED) and still raises the level by one.
- R5: A trap taken when the level is at or above the effective maximum is not accepted. It moves the block to `ST_ERR`, and from the next cycle `err_state_o` stays 1 until reset. In `ST_ERR` traps, returns and writes change nothing.
- R6: An accepted trap writes the trap PC, the next PC and the saved word into slot (new level mod 8). The `top_*` outputs always show slot (level mod 8).
- R7: Saved word layout: bits 39:32 hold the condition codes, 31:24 the ASI, 19:8 the processor state ANDed with 0xF3F (with RED already applied), 7:0 the zero-extended window pointer, and all other bits are zero.
- R8: A return at a nonzero level loads the processor state from word bits 19:8 ANDed with 0xF3F and the window pointer from the low word bits, then lowers the level by one. The resume PC becomes the trap PC for retry (`ret_retry_i`=1) and the next PC for done.
- R9: A return at level 0 changes nothing, and `ill_ret_o` is 1 for the following cycle only.
- R10: When a trap and a return are requested in the same cycle, only the trap is handled.
- R11: A state write (`pst_we_i`) loads the processor state and window pointer only when neither a trap nor a return is requested and the block is in `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| max_tl_i | input | 4 | Configured maximum trap level |
| trap_req_i | input | 1 | Trap request |
| trap_pc_i | input | 64 | PC to save for the trap |
| trap_npc_i | input | 64 | Next PC to save for the trap |
| ccr_i | input | 8 | Current condition codes |
| asi_i | input | 8 | Current address space identifier |
| ret_req_i | input | 1 | Return (done or retry) request |
| ret_retry_i | input | 1 | 1 = retry, 0 = done |
| pst_we_i | input | 1 | Direct state write enable |
| pst_wdata_i | input | 12 | Processor state write value |
| cwp_wdata_i | input | 3 | Window pointer write value |
| tl_o | output | 4 | Current trap level |
| pstate_o | output | 12 | Processor state |
| cwp_o | output | 3 | Current window pointer |
| resume_pc_o | output | 64 | PC selected by the last return |
| top_tpc_o | output | 64 | Trap PC in the slot of the current level |
| top_tnpc_o | output | 64 | Next PC in the slot of the current level |
| top_tstate_o | output | 64 | Saved word in the slot of the current level |
| err_state_o | output | 1 | Error state reached |
| ill_ret_o | output | 1 | One-cycle flag for a return at level 0 |
| version_o | output | 16 | Maximum level and window count field |

## Verification
If the level register is wrong, the fault shows on `tl_o` and in the `top_*` slot outputs in the next cycle. It also decides when RED is set and when the error state is entered a few traps later. A wrong slot index or a wrong packing stays hidden until the matching return. At that return `pstate_o`, `cwp_o` and `resume_pc_o` take the wrong values. For this reason the bench always unwinds each trap it takes. A slip in the controller state shows as `err_state_o` or `ill_ret_o` one cycle after the request that caused it.

// File: rtl/tstk_pkg.sv
package tstk_pkg;
    localparam int WORD_W = 64;
    localparam int PST_W  = 12;
    localparam logic [PST_W-1:0] PST_KEEP = 12'hF3F;
    localparam int PRIV_BIT = 2;
    localparam int RED_BIT  = 5;

    typedef enum logic {ST_RUN, ST_ERR} ctl_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] tpc;
        logic [WORD_W-1:0] tnpc;
        logic [WORD_W-1:0] tstate;
    } tframe_t;

    // saved word: ccr 39:32, asi 31:24, masked state 19:8, window 7:0
    function automatic logic [WORD_W-1:0] pack_state(
        input logic [7:0]       ccr,
        input logic [7:0]       asi,
        input logic [PST_W-1:0] pst,
        input logic [7:0]       cwp);
        return {24'd0, ccr, asi, 4'd0, pst & PST_KEEP, cwp};
    endfunction
endpackage

// File: rtl/tstk_ctrl.sv
module tstk_ctrl
    import tstk_pkg::*;
#(
    parameter int MAX_TL = 8,
    localparam int LVL_W = $clog2(MAX_TL + 1),
    localparam int IDX_W = $clog2(MAX_TL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] max_tl_i,
    input  logic             trap_req_i,
    input  logic             ret_req_i,
    output logic [LVL_W-1:0] tl_o,
    output logic [LVL_W-1:0] max_eff_o,
    output logic             acc_trap_o,
    output logic             acc_ret_o,
    output logic             red_o,
    output logic             err_o,
    output logic             ill_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [IDX_W-1:0] rd_idx_o
);
    ctl_state_e       st_q, st_nx;
    logic [LVL_W-1:0] tl_q, tl_nx, max_eff;
    logic             ill_q, ill_nx;

    always_comb begin
        if (max_tl_i == '0)
            max_eff = LVL_W'(1);
        else if (max_tl_i > LVL_W'(MAX_TL))
            max_eff = LVL_W'(MAX_TL);
        else
            max_eff = max_tl_i;
    end

    always_comb begin
        st_nx      = st_q;
        tl_nx      = tl_q;
        acc_trap_o = 1'b0;
        acc_ret_o  = 1'b0;
        red_o      = 1'b0;
        ill_nx     = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (trap_req_i) begin
                    if (tl_q >= max_eff) begin
                        st_nx = ST_ERR;
                    end else begin
                        acc_trap_o = 1'b1;
                        tl_nx      = tl_q + LVL_W'(1);
                        red_o      = (tl_q >= max_eff - LVL_W'(1));
                    end
                end else if (ret_req_i) begin
                    if (tl_q == '0) begin
                        ill_nx = 1'b1;
                    end else begin
                        acc_ret_o = 1'b1;
                        tl_nx     = tl_q - LVL_W'(1);
                    end
                end
            end
            ST_ERR: begin
                st_nx = ST_ERR;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_nx;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q  <= max_eff;
            ill_q <= 1'b0;
        end else begin
            tl_q  <= tl_nx;
            ill_q <= ill_nx;
        end
    end

    assign tl_o      = tl_q;
    assign max_eff_o = max_eff;
    assign err_o     = (st_q == ST_ERR);
    assign ill_o     = ill_q;
    assign wr_idx_o  = tl_nx[IDX_W-1:0];
    assign rd_idx_o  = tl_q[IDX_W-1:0];

    // R6
    tl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tl_q <= LVL_W'(MAX_TL));
    // R5
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    // R3
    trap_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && trap_req_i && tl_q < max_eff)
        |=> (tl_q == $past(tl_q) + LVL_W'(1)));
    // R9
    ill_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !trap_req_i && ret_req_i && tl_q == '0)
        |=> (ill_o && tl_q == '0));
endmodule

// File: rtl/tstk_store.sv
module tstk_store
    import tstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  tframe_t          wr_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output tframe_t          rd_o
);
    tframe_t rows [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        tframe_t slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (we_i && wr_idx_i == IDX_W'(e))
                slot_q <= wr_i;
        end
        assign rows[e] = slot_q;
    end

    assign rd_o = rows[rd_idx_i];
endmodule

// File: rtl/trap_level_stack.sv
module trap_level_stack
    import tstk_pkg::*;
#(
    parameter int MAX_TL = 8,
    parameter int CWP_W  = 3,
    parameter int NWIN   = 8,
    localparam int LVL_W = $clog2(MAX_TL + 1),
    localparam int IDX_W = $clog2(MAX_TL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  max_tl_i,
    input  logic              trap_req_i,
    input  logic [WORD_W-1:0] trap_pc_i,
    input  logic [WORD_W-1:0] trap_npc_i,
    input  logic [7:0]        ccr_i,
    input  logic [7:0]        asi_i,
    input  logic              ret_req_i,
    input  logic              ret_retry_i,
    input  logic              pst_we_i,
    input  logic [PST_W-1:0]  pst_wdata_i,
    input  logic [CWP_W-1:0]  cwp_wdata_i,
    output logic [LVL_W-1:0]  tl_o,
    output logic [PST_W-1:0]  pstate_o,
    output logic [CWP_W-1:0]  cwp_o,
    output logic [WORD_W-1:0] resume_pc_o,
    output logic [WORD_W-1:0] top_tpc_o,
    output logic [WORD_W-1:0] top_tnpc_o,
    output logic [WORD_W-1:0] top_tstate_o,
    output logic              err_state_o,
    output logic              ill_ret_o,
    output logic [15:0]       version_o
);
    localparam logic [PST_W-1:0] RED_MASK  = PST_W'(1) << RED_BIT;
    localparam logic [PST_W-1:0] PRIV_MASK = PST_W'(1) << PRIV_BIT;

    logic             acc_trap, acc_ret, red_hit, err;
    logic [LVL_W-1:0] max_eff;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    tframe_t          wr_frame, rd_frame;
    logic [PST_W-1:0] pst_q, pst_cap;
    logic [CWP_W-1:0] cwp_q;
    logic [WORD_W-1:0] res_q;

    tstk_ctrl #(.MAX_TL(MAX_TL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .max_tl_i(max_tl_i),
        .trap_req_i(trap_req_i), .ret_req_i(ret_req_i),
        .tl_o(tl_o), .max_eff_o(max_eff),
        .acc_trap_o(acc_trap), .acc_ret_o(acc_ret), .red_o(red_hit),
        .err_o(err), .ill_o(ill_ret_o),
        .wr_idx_o(wr_idx), .rd_idx_o(rd_idx)
    );

    assign pst_cap  = red_hit ? (pst_q | RED_MASK) : pst_q;
    assign wr_frame = '{tpc: trap_pc_i, tnpc: trap_npc_i,
                        tstate: pack_state(ccr_i, asi_i, pst_cap, 8'(cwp_q))};

    tstk_store #(.DEPTH(MAX_TL)) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(acc_trap), .wr_idx_i(wr_idx),
        .wr_i(wr_frame), .rd_idx_i(rd_idx), .rd_o(rd_frame)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst_q <= PRIV_MASK;
            cwp_q <= '0;
            res_q <= '0;
        end else if (acc_trap) begin
            pst_q <= pst_cap;
        end else if (acc_ret) begin
            pst_q <= rd_frame.tstate[8 +: PST_W] & PST_KEEP;
            cwp_q <= rd_frame.tstate[CWP_W-1:0];
            res_q <= ret_retry_i ? rd_frame.tpc : rd_frame.tnpc;
        end else if (pst_we_i && !trap_req_i && !ret_req_i && !err) begin
            pst_q <= pst_wdata_i;
            cwp_q <= cwp_wdata_i;
        end
    end

    assign pstate_o     = pst_q;
    assign cwp_o        = cwp_q;
    assign resume_pc_o  = res_q;
    assign top_tpc_o    = rd_frame.tpc;
    assign top_tnpc_o   = rd_frame.tnpc;
    assign top_tstate_o = rd_frame.tstate;
    assign err_state_o  = err;
    assign version_o    = {8'(max_eff), 8'(NWIN - 1)};

    // R8
    ret_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ret |=> (pstate_o[7:6] == 2'b00));
    // R4
    red_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_trap && red_hit) |=> pstate_o[RED_BIT]);
endmodule

// File: tb/tb_trap_level_stack.sv
module tb_trap_level_stack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  max_tl_i = 4'd5;
    logic        trap_req_i = 1'b0, ret_req_i = 1'b0, ret_retry_i = 1'b0, pst_we_i = 1'b0;
    logic [63:0] trap_pc_i = '0, trap_npc_i = '0;
    logic [7:0]  ccr_i = '0, asi_i = '0;
    logic [11:0] pst_wdata_i = '0;
    logic [2:0]  cwp_wdata_i = '0;
    logic [3:0]  tl_o;
    logic [11:0] pstate_o;
    logic [2:0]  cwp_o;
    logic [63:0] resume_pc_o, top_tpc_o, top_tnpc_o, top_tstate_o;
    logic        err_state_o, ill_ret_o;
    logic [15:0] version_o;

    always #5 clk = ~clk;

    trap_level_stack dut (
        .clk(clk), .rst_n(rst_n), .max_tl_i(max_tl_i),
        .trap_req_i(trap_req_i), .trap_pc_i(trap_pc_i), .trap_npc_i(trap_npc_i),
        .ccr_i(ccr_i), .asi_i(asi_i), .ret_req_i(ret_req_i), .ret_retry_i(ret_retry_i),
        .pst_we_i(pst_we_i), .pst_wdata_i(pst_wdata_i), .cwp_wdata_i(cwp_wdata_i),
        .tl_o(tl_o), .pstate_o(pstate_o), .cwp_o(cwp_o), .resume_pc_o(resume_pc_o),
        .top_tpc_o(top_tpc_o), .top_tnpc_o(top_tnpc_o), .top_tstate_o(top_tstate_o),
        .err_state_o(err_state_o), .ill_ret_o(ill_ret_o), .version_o(version_o)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    int          m_tl, m_pst, m_cwp, m_err, m_ill;
    logic [63:0] m_res;
    logic [63:0] m_tpc [8];
    logic [63:0] m_tnpc [8];
    logic [63:0] m_ts [8];

    function automatic int eff_max();
        if (max_tl_i == 0) return 1;
        if (max_tl_i > 8) return 8;
        return int'(max_tl_i);
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        int ix = m_tl % 8;
        chk("R3", {tag, " level"}, 64'(tl_o), 64'(m_tl));
        chk("R4", {tag, " pstate"}, 64'(pstate_o), 64'(m_pst));
        chk("R8", {tag, " window"}, 64'(cwp_o), 64'(m_cwp));
        chk("R8", {tag, " resume"}, resume_pc_o, m_res);
        chk("R5", {tag, " error"}, 64'(err_state_o), 64'(m_err));
        chk("R9", {tag, " illegal"}, 64'(ill_ret_o), 64'(m_ill));
        chk("R6", {tag, " top tpc"}, top_tpc_o, m_tpc[ix]);
        chk("R6", {tag, " top tnpc"}, top_tnpc_o, m_tnpc[ix]);
        chk("R7", {tag, " top word"}, top_tstate_o, m_ts[ix]);
        chk("R2", {tag, " version"}, 64'(version_o), 64'({8'(eff_max()), 8'd7}));
    endtask

    task automatic model_reset();
        m_tl = eff_max(); m_pst = 'h004; m_cwp = 0; m_err = 0; m_ill = 0; m_res = '0;
        for (int k = 0; k < 8; k++) begin
            m_tpc[k] = '0; m_tnpc[k] = '0; m_ts[k] = '0;
        end
    endtask

    task automatic model_step();
        int mx = eff_max();
        int cap, ix;
        m_ill = 0;
        if (m_err == 0) begin
            if (trap_req_i) begin
                if (m_tl >= mx) m_err = 1;
                else begin
                    cap = (m_tl >= mx - 1) ? (m_pst | 'h020) : m_pst;
                    m_pst = cap;
                    m_tl++;
                    ix = m_tl % 8;
                    m_tpc[ix] = trap_pc_i;
                    m_tnpc[ix] = trap_npc_i;
                    m_ts[ix] = (64'(ccr_i) << 32) | (64'(asi_i) << 24) |
                               (64'(cap & 'hF3F) << 8) | 64'(m_cwp);
                end
            end else if (ret_req_i) begin
                if (m_tl == 0) m_ill = 1;
                else begin
                    ix = m_tl % 8;
                    m_pst = int'((m_ts[ix] >> 8) & 64'hF3F);
                    m_cwp = int'(m_ts[ix] & 64'h7);
                    m_res = ret_retry_i ? m_tpc[ix] : m_tnpc[ix];
                    m_tl--;
                end
            end else if (pst_we_i) begin
                m_pst = int'(pst_wdata_i);
                m_cwp = int'(cwp_wdata_i);
            end
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        trap_req_i = 0; ret_req_i = 0; ret_retry_i = 0; pst_we_i = 0;
        compare_all(tag);
    endtask

    task automatic set_data(input int seed);
        trap_pc_i  = 64'h0000_4000_0000_0000 + 64'(seed) * 64'h1_0004;
        trap_npc_i = 64'h0000_8000_0000_0000 + 64'(seed) * 64'h2_0108;
        ccr_i      = 8'(seed * 11 + 5);
        asi_i      = 8'(seed * 37 + 3);
    endtask

    task automatic do_trap(input string tag, input int seed);
        set_data(seed); trap_req_i = 1; step(tag);
    endtask
    task automatic do_ret(input string tag, input bit retry);
        ret_req_i = 1; ret_retry_i = retry; step(tag);
    endtask
    task automatic do_wr(input string tag, input logic [11:0] p, input logic [2:0] c);
        pst_we_i = 1; pst_wdata_i = p; cwp_wdata_i = c; step(tag);
    endtask
    task automatic do_both(input string tag, input int seed);
        set_data(seed); trap_req_i = 1; ret_req_i = 1; pst_we_i = 1; pst_wdata_i = 12'h111; step(tag);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        compare_all("R1 reset");
        // unwind reset level 5 down to 0 through zero slots
        for (int k = 0; k < 5; k++) do_ret("R8 unwind", k[0]);
        do_ret("R9 return at zero", 0);
        do_ret("R9 second zero return", 1);
        do_wr("R11 write", 12'hFC7, 3'd3);
        do_trap("R3 first", 1);
        do_trap("R7 second", 2);
        do_both("R10 trap and return", 3);
        do_wr("R11 write", 12'hFFF, 3'd6);
        do_trap("R3 fourth", 4);
        do_trap("R4 last level", 5);
        do_ret("R8 retry", 1);
        do_ret("R7 done", 0);
        do_ret("R8 retry", 1);
        do_ret("R8 done", 0);
        do_ret("R8 retry", 1);
        do_wr("R11 write", 12'h0C2, 3'd1);
        do_ret("R9 zero again", 0);
        max_tl_i = 4'd0;
        do_trap("R2 max zero", 6);
        do_ret("R2 back", 1);
        max_tl_i = 4'd12;
        for (int k = 0; k < 8; k++) do_trap("R6 fill eight", 10 + k);
        do_ret("R6 wrapped slot", 1);
        do_trap("R6 refill", 20);
        do_trap("R5 overflow", 21);
        do_trap("R5 ignored trap", 22);
        do_ret("R5 ignored return", 1);
        do_wr("R5 ignored write", 12'h000, 3'd0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule